// File: doc/BRIEF.md
# Debug Channel Test Access Port

This block is a JTAG-compatible test access port. A host drives TCK, TMS and TDI. The block steps through the standard sixteen-state controller, holds a 3-bit instruction and sends each data scan to one of two registers. Instruction code 010b selects a 10-bit debug register. Every other code selects a 1-bit bypass register.

While the debug instruction is in force, the 10-bit register is a two-way channel to an on-chip debug engine. On Capture-DR it loads a word offered by the engine. On Update-DR it hands the shifted word to the engine with a one-cycle strobe. The instruction stays in force across any number of data scans. It is replaced only by a later instruction scan, by the controller reaching Test-Logic-Reset, or by the asynchronous reset pin.

Top module: `dbg_tap`

## Requirements
- R1: While `trst_n` is low the controller sits in Test-Logic-Reset, the held instruction is all ones (bypass), `tdo` and `tdo_oe` are 0 and `eng_wr_valid` is 0; the reset acts without a TCK edge.
- R2: The controller advances on the rising edge of `tck` following the standard sixteen-state TMS transitions, including the Pause and Exit2 paths of both scan columns.
- R3: Five consecutive TCK cycles with TMS high reach Test-Logic-Reset from any state, and that state loads the bypass instruction (111b).
- R4: Capture-IR loads 001b into the instruction shift register, so the first three TDO bits of an instruction scan are 1, 0, 0.
- R5: The instruction is shifted in least significant bit first and is applied to the data path at Update-IR.
- R6: Instruction 010b selects the 10-bit debug register for data scans, and the selection holds over later data scans until the next instruction scan or reset.
- R7: Any other instruction code selects a 1-bit bypass register that captures 0, so TDO repeats TDI one bit late.
- R8: With the debug instruction active, Capture-DR loads `eng_rd_data` into the debug register.
- R9: With the debug instruction active, Update-DR drives the shifted word on `eng_wr_data` and raises `eng_wr_valid` for exactly one TCK cycle. In bypass neither output changes.
- R10: The debug register shifts least significant bit first: TDI enters at bit 9 and TDO is taken from bit 0.
- R11: TDO changes only on the falling edge of `tck`. It is driven, with `tdo_oe` high, only in Shift-IR and Shift-DR. In every other state `tdo` is 0 and `tdo_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_oe | output | 1 | High while tdo carries shift data |
| eng_rd_data | input | 10 | Word from the debug engine, loaded at Capture-DR |
| eng_wr_data | output | 10 | Word to the debug engine, set at Update-DR |
| eng_wr_valid | output | 1 | One-cycle strobe marking a new eng_wr_data |

## Verification
Data scans run under three instructions: the debug code, bypass (111b) and an unused code (101b). The scan length of 10 bits against 8 bits, and whether TDO shows the engine word or a delayed copy of TDI, show which register was selected. Asymmetric words such as 0x001 and 0x2A5 prove bit order and catch a reversed shift. Reaching reset through the TMS sequence, including from the middle of a shift, and through `trst_n` shows that the held instruction falls back to bypass. Scans routed through the Pause and Exit2 states exercise the less common controller arcs.

// File: rtl/dbg_tap_pkg.sv
// Package: shared controller state type and next-state function for the
// debug-channel test access port. Assumes the standard 16-state controller.
package dbg_tap_pkg;

    typedef enum logic [3:0] {
        ST_RESET   = 4'd0,
        ST_IDLE    = 4'd1,
        ST_SEL_DR  = 4'd2,
        ST_CAP_DR  = 4'd3,
        ST_SH_DR   = 4'd4,
        ST_EX1_DR  = 4'd5,
        ST_PAU_DR  = 4'd6,
        ST_EX2_DR  = 4'd7,
        ST_UPD_DR  = 4'd8,
        ST_SEL_IR  = 4'd9,
        ST_CAP_IR  = 4'd10,
        ST_SH_IR   = 4'd11,
        ST_EX1_IR  = 4'd12,
        ST_PAU_IR  = 4'd13,
        ST_EX2_IR  = 4'd14,
        ST_UPD_IR  = 4'd15
    } tap_state_e;

    // Standard TMS-driven transition of the controller.
    function automatic tap_state_e tap_next(input tap_state_e cur, input logic m);
        case (cur)
            ST_RESET:  return m ? ST_RESET  : ST_IDLE;
            ST_IDLE:   return m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: return m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: return m ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
            default:   return m ? ST_SEL_DR : ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/dbg_tap_fsm.sv
// Module: controller state register.
// Assumes: tms is stable around the rising edge of tck; trst_n is asynchronous.
module dbg_tap_fsm
    import dbg_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    // Advance the controller on each rising TCK edge; reset forces Test-Logic-Reset.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= tap_next(state, tms);
    end

endmodule

// File: rtl/dbg_tap_ir.sv
// Module: instruction shift register and held instruction.
// Assumes: IR_W >= 2; the capture pattern is ...001 with the LSB shifted out first.
module dbg_tap_ir
    import dbg_tap_pkg::*;
#(
    parameter int IR_W = 3
) (
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_sr,
    output logic [IR_W-1:0] ir_hold
);

    localparam logic [IR_W-1:0] CAP_PAT = IR_W'(1);
    localparam logic [IR_W-1:0] BYPASS  = '1;

    // Capture the fixed pattern, then shift towards bit 0 with TDI entering at the top.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                ir_sr <= CAP_PAT;
        else if (state == ST_CAP_IR) ir_sr <= CAP_PAT;
        else if (state == ST_SH_IR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Hold the instruction: loaded at Update-IR, forced to bypass in Test-Logic-Reset.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                 ir_hold <= BYPASS;
        else if (state == ST_RESET)  ir_hold <= BYPASS;
        else if (state == ST_UPD_IR) ir_hold <= ir_sr;
    end

endmodule

// File: rtl/dbg_tap_dr.sv
// Module: data registers, the 1-bit bypass and the debug channel register,
// with the parallel capture/update interface to the debug engine.
// Assumes: dbg_sel is stable throughout a data scan (it changes only at Update-IR or reset).
module dbg_tap_dr
    import dbg_tap_pkg::*;
#(
    parameter int DR_W = 10
) (
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_e      state,
    input  logic            tdi,
    input  logic            dbg_sel,
    input  logic [DR_W-1:0] eng_rd_data,
    output logic [DR_W-1:0] dbg_sr,
    output logic            dr_tdo,
    output logic [DR_W-1:0] eng_wr_data,
    output logic            eng_wr_valid
);

    logic byp_q;

    // Bypass cell: captures 0 and passes TDI through one stage.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                 byp_q <= 1'b0;
        else if (state == ST_CAP_DR) byp_q <= 1'b0;
        else if (state == ST_SH_DR)  byp_q <= tdi;
    end

    // Debug register: load the engine word, then shift LSB first.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                             dbg_sr <= '0;
        else if (dbg_sel && state == ST_CAP_DR)  dbg_sr <= eng_rd_data;
        else if (dbg_sel && state == ST_SH_DR)   dbg_sr <= {tdi, dbg_sr[DR_W-1:1]};
    end

    // Engine output word: updated only at Update-DR under the debug instruction.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                            eng_wr_data <= '0;
        else if (dbg_sel && state == ST_UPD_DR) eng_wr_data <= dbg_sr;
    end

    // Strobe: high for the one TCK cycle that follows the update.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) eng_wr_valid <= 1'b0;
        else         eng_wr_valid <= dbg_sel && (state == ST_UPD_DR);
    end

    // Serial output of whichever data register the instruction selects.
    always_comb dr_tdo = dbg_sel ? dbg_sr[0] : byp_q;

endmodule

// File: rtl/dbg_tap.sv
// Module: top of the debug-channel test access port. It joins the controller,
// the instruction path and the data path, and times TDO off the falling TCK edge.
// Assumes: the host samples tdo on rising tck.
module dbg_tap
    import dbg_tap_pkg::*;
#(
    parameter int              IR_W     = 3,
    parameter int              DR_W     = 10,
    parameter logic [IR_W-1:0] DBG_CODE = 3'b010
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tms,
    input  logic            tdi,
    output logic            tdo,
    output logic            tdo_oe,
    input  logic [DR_W-1:0] eng_rd_data,
    output logic [DR_W-1:0] eng_wr_data,
    output logic            eng_wr_valid
);

    tap_state_e      state;
    logic [IR_W-1:0] ir_sr;
    logic [IR_W-1:0] ir_hold;
    logic [DR_W-1:0] dbg_sr;
    logic            dbg_sel;
    logic            dr_tdo;

    dbg_tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    dbg_tap_ir #(.IR_W(IR_W)) u_ir (
        .tck     (tck),
        .trst_n  (trst_n),
        .state   (state),
        .tdi     (tdi),
        .ir_sr   (ir_sr),
        .ir_hold (ir_hold)
    );

    // Instruction decode: the debug code picks the wide register, all else bypass.
    always_comb dbg_sel = (ir_hold == DBG_CODE);

    dbg_tap_dr #(.DR_W(DR_W)) u_dr (
        .tck          (tck),
        .trst_n       (trst_n),
        .state        (state),
        .tdi          (tdi),
        .dbg_sel      (dbg_sel),
        .eng_rd_data  (eng_rd_data),
        .dbg_sr       (dbg_sr),
        .dr_tdo       (dr_tdo),
        .eng_wr_data  (eng_wr_data),
        .eng_wr_valid (eng_wr_valid)
    );

    // Output stage: on falling TCK, drive the shift bit in the shift states, else 0.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else if (state == ST_SH_IR) begin
            tdo    <= ir_sr[0];
            tdo_oe <= 1'b1;
        end else if (state == ST_SH_DR) begin
            tdo    <= dr_tdo;
            tdo_oe <= 1'b1;
        end else begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end
    end

endmodule

// File: rtl/dbg_tap_chk.sv
// Module: assertion checker bound to dbg_tap; observes ports and internal state only.
module dbg_tap_chk
    import dbg_tap_pkg::*;
#(
    parameter int IR_W = 3,
    parameter int DR_W = 10
) (
    input logic            tck,
    input logic            trst_n,
    input tap_state_e      state,
    input logic [IR_W-1:0] ir_sr,
    input logic [IR_W-1:0] ir_hold,
    input logic            dbg_sel,
    input logic [DR_W-1:0] dbg_sr,
    input logic [DR_W-1:0] eng_rd_data,
    input logic            tdo,
    input logic            tdo_oe,
    input logic            eng_wr_valid
);

    // R11
    oe_only_in_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));

    // R11
    tdo_quiet_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !tdo_oe |-> !tdo);

    // R3
    reset_loads_bypass_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_RESET) |=> (ir_hold == '1));

    // R4
    ir_capture_pattern_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_IR) |=> (ir_sr == IR_W'(1)));

    // R8
    dbg_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (dbg_sel && state == ST_CAP_DR) |=> (dbg_sr == $past(eng_rd_data)));

    // R9
    strobe_single_chk: assert property (@(posedge tck) disable iff (!trst_n)
        eng_wr_valid |=> !eng_wr_valid);

    // R9
    strobe_after_update_chk: assert property (@(posedge tck) disable iff (!trst_n)
        eng_wr_valid |-> ($past(state) == ST_UPD_DR));

endmodule

bind dbg_tap dbg_tap_chk #(.IR_W(IR_W), .DR_W(DR_W)) u_chk (
    .tck          (tck),
    .trst_n       (trst_n),
    .state        (state),
    .ir_sr        (ir_sr),
    .ir_hold      (ir_hold),
    .dbg_sel      (dbg_sel),
    .dbg_sr       (dbg_sr),
    .eng_rd_data  (eng_rd_data),
    .tdo          (tdo),
    .tdo_oe       (tdo_oe),
    .eng_wr_valid (eng_wr_valid)
);

// File: tb/dbg_tap_tb_top.sv
// Directed bench for dbg_tap: one task per scenario, each checking its own results.
module dbg_tap_tb_top;

    logic       tck = 1'b0;
    logic       trst_n = 1'b0;
    logic       tms = 1'b1;
    logic       tdi = 1'b0;
    logic       tdo;
    logic       tdo_oe;
    logic [9:0] eng_rd_data = '0;
    logic [9:0] eng_wr_data;
    logic       eng_wr_valid;

    int n_chk = 0;
    int n_err = 0;

    always #5 tck = ~tck;

    dbg_tap dut_i (
        .tck          (tck),
        .trst_n       (trst_n),
        .tms          (tms),
        .tdi          (tdi),
        .tdo          (tdo),
        .tdo_oe       (tdo_oe),
        .eng_rd_data  (eng_rd_data),
        .eng_wr_data  (eng_wr_data),
        .eng_wr_valid (eng_wr_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One TCK cycle: sample outputs after the falling edge, then drive the inputs.
    task automatic tick(input logic m, input logic d, output logic o_do, output logic o_oe);
        @(negedge tck);
        #2;
        o_do = tdo;
        o_oe = tdo_oe;
        tms  = m;
        tdi  = d;
    endtask

    task automatic tk(input logic m);
        logic a, b;
        tick(m, 1'b0, a, b);
    endtask

    // Instruction scan from Run-Test/Idle, routed through Pause-IR and Exit2-IR.
    task automatic scan_ir(input logic [2:0] code, output logic [2:0] cap, output logic oe_all);
        logic a, b;
        oe_all = 1'b1;
        tk(1); tk(1); tk(0); tk(0);
        for (int i = 0; i < 3; i++) begin
            tick(i == 2, code[i], a, b);
            cap[i] = a;
            oe_all = oe_all & b;
        end
        tk(0); tk(0); tk(1); tk(1); tk(0);
    endtask

    // Data scan of n bits from Run-Test/Idle, ending back in Run-Test/Idle.
    task automatic scan_dr(input int n, input logic [15:0] din, output logic [15:0] dout);
        logic a, b;
        dout = '0;
        tk(1); tk(0); tk(0);
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, din[i], a, b);
            dout[i] = a;
        end
        tk(1); tk(0);
    endtask

    task automatic do_reset();
        trst_n = 1'b0;
        tms = 1'b1;
        repeat (2) @(negedge tck);
        #2;
        trst_n = 1'b1;
        tk(0);
    endtask

    task automatic t_reset_state();
        logic a, b;
        trst_n = 1'b0;
        #13;
        // R1: outputs are quiet while reset is held, without needing an edge
        chk(tdo == 0 && tdo_oe == 0, "R1 tdo/oe in reset", {tdo, tdo_oe}, 0);
        chk(eng_wr_valid == 0, "R1 strobe in reset", eng_wr_valid, 0);
        do_reset();
        // R1: after reset the held instruction is bypass
        tick(0, 0, a, b);
        chk(b == 0, "R11 oe low in idle", b, 0);
    endtask

    task automatic t_ir_capture();
        logic [2:0] cap;
        logic oe;
        scan_ir(3'b010, cap, oe);
        // R4: Capture-IR pattern 001, LSB first
        chk(cap == 3'b001, "R4 capture-IR pattern", cap, 3'b001);
        chk(oe == 1'b1, "R11 oe high in Shift-IR", oe, 1);
    endtask

    task automatic t_debug_scan(input logic [9:0] rd, input logic [9:0] wr);
        logic [15:0] out;
        logic a, b;
        eng_rd_data = rd;
        scan_dr(10, {6'b0, wr}, out);
        // R8 and R10: the engine word comes out LSB first
        chk(out[9:0] == rd, "R8 R10 captured engine word", out[9:0], rd);
        tick(0, 0, a, b);
        // R9: word and strobe in the cycle after Update-DR
        chk(eng_wr_valid == 1'b1, "R9 strobe raised", eng_wr_valid, 1);
        chk(eng_wr_data == wr, "R9 R10 update word", eng_wr_data, wr);
        tick(0, 0, a, b);
        chk(eng_wr_valid == 1'b0, "R9 strobe one cycle", eng_wr_valid, 0);
    endtask

    task automatic t_bypass(input string tag);
        logic [15:0] out;
        logic [9:0]  old_wr;
        logic [7:0]  din;
        logic [7:0]  exp;
        logic a, b;
        din = 8'b1011_0011;
        exp = {din[6:0], 1'b0};
        old_wr = eng_wr_data;
        eng_rd_data = 10'h3FF;
        scan_dr(8, {8'b0, din}, out);
        // R7: one-bit delay with captured 0
        chk(out[7:0] == exp, {"R7 bypass path ", tag}, out[7:0], exp);
        tick(0, 0, a, b);
        chk(eng_wr_valid == 1'b0 && eng_wr_data == old_wr, {"R9 no update in bypass ", tag},
            {eng_wr_valid, eng_wr_data}, {1'b0, old_wr});
    endtask

    task automatic t_tdo_edge();
        logic a, b, v0;
        eng_rd_data = 10'b01_0101_0101;
        tk(1); tk(0); tk(0);
        tick(0, 1'b0, a, b);
        v0 = a;
        @(posedge tck);
        #1;
        // R11: a rising edge must not move TDO
        chk(tdo == v0 && v0 == 1'b1, "R11 tdo steady at rising edge", tdo, 1);
        tick(0, 1'b0, a, b);
        chk(a == 1'b0, "R11 tdo moved at falling edge", a, 0);
        for (int i = 2; i < 10; i++) tick(i == 9, 1'b0, a, b);
        tk(1); tk(0);
        tick(0, 0, a, b);
        tick(0, 0, a, b);
    endtask

    task automatic t_tms_reset_mid_shift();
        logic a, b;
        tk(1); tk(0); tk(0); tk(0);
        tick(1, 0, a, b);
        chk(b == 1'b1, "R11 oe in Shift-DR", b, 1);
        repeat (4) tk(1);
        tick(0, 0, a, b);
        // R3: five TMS-high cycles from Shift-DR reach reset; outputs quiet
        chk(b == 1'b0 && a == 1'b0, "R3 quiet after TMS reset", {a, b}, 0);
        tk(0);
    endtask

    task automatic t_trst_async();
        #3;
        trst_n = 1'b0;
        #3;
        trst_n = 1'b1;
        tk(0);
        tk(0);
    endtask

    logic [2:0] cap_v;
    logic       oe_v;

    initial begin
        t_reset_state();
        t_bypass("after R1 reset");
        t_ir_capture();
        // R5 R6: debug code loaded; first scan
        t_debug_scan(10'h2A5, 10'h15A);
        // R6: selection held, new words (R10 asymmetric)
        t_debug_scan(10'h001, 10'h200);
        t_debug_scan(10'h3C0, 10'h001);
        t_tdo_edge();
        scan_ir(3'b111, cap_v, oe_v);
        t_bypass("code 111");
        scan_ir(3'b101, cap_v, oe_v);
        t_bypass("code 101");
        // R3: TMS reset from idle drops the debug instruction
        scan_ir(3'b010, cap_v, oe_v);
        t_debug_scan(10'h0F3, 10'h30C);
        repeat (5) tk(1);
        tk(0);
        t_bypass("R3 after TMS reset");
        // R3: TMS reset from inside a shift
        scan_ir(3'b010, cap_v, oe_v);
        t_tms_reset_mid_shift();
        t_bypass("R3 mid-shift reset");
        // R1: asynchronous reset pin drops the debug instruction
        scan_ir(3'b010, cap_v, oe_v);
        t_trst_async();
        t_bypass("R1 trst");
        // R2: the Pause/Exit2 path was used by every instruction scan; confirm debug again
        scan_ir(3'b010, cap_v, oe_v);
        t_debug_scan(10'h155, 10'h2AA);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule